// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Controller

This block sits on the host side of a serial flash and turns read requests into bus transactions. A request carries a 24-bit byte address and a byte count, and it arrives on a valid/ready handshake. The controller lowers chip select and issues the fast-read opcode `0x0B` followed by the address. It then runs a configurable number of dummy clocks and clocks in the requested bytes. Each byte leaves the block on a one-cycle output pulse, together with the address it came from.

A run-time lane selector sets how wide every phase of a transaction is. In single-line mode, one bit moves per clock: out on DQ0 and in on DQ1. In dual mode, two bits move per clock on DQ1:DQ0, and in quad mode, four bits move per clock on DQ3:DQ0. This applies to the opcode, the address and the data alike. The serial clock runs at half the system clock in SPI mode 0. The data lines are driven through separate value and enable outputs, so the tristate pad can sit outside the block.

An execute-in-place mode saves the opcode on repeated reads. After an enable strobe, the next transaction still sends the opcode, and every later transaction sends only the address before the dummy clocks. An exit strobe restores the opcode on the next read. A wrap input makes the sequential byte addresses wrap inside an aligned 16-byte block, matching a memory set to the same wrap behaviour.

Top module: `flash_rd_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_dq_oe` is 0, `req_ready` is 1 and `out_valid` is 0; whenever `spi_cs_n` is high, `spi_sck` is low.
- R2: With `cfg_lanes` = 0 (code 3 behaves the same), a transaction shifts opcode `0x0B` and then the 24-bit address, most significant bit first, one bit per clock on DQ0 with only `spi_dq_oe[0]` set. Data bits are taken from DQ1, so a read of N bytes spans 32 + dummy + 8N serial clocks.
- R3: With `cfg_lanes` = 1, every phase moves two bits per clock on DQ1:DQ0, the higher bit on DQ1. The enable is `4'b0011` while sending, and a read spans 16 + dummy + 4N clocks.
- R4: With `cfg_lanes` = 2, every phase moves four bits per clock on DQ3:DQ0, the highest bit on DQ3. The enable is `4'b1111` while sending, and a read spans 8 + dummy + 2N clocks.
- R5: Exactly `cfg_dummy` clocks (zero allowed) separate the last address clock from the first data clock. `spi_dq_oe` is all zero from the falling edge that ends the address until chip select rises.
- R6: Chip select falls once per transaction and stays low until its end. `spi_dq_o` and `spi_dq_oe` change only together with a falling edge of `spi_sck`, and data is captured on the rising edge.
- R7: A read of N bytes yields exactly N `out_valid` pulses, never on consecutive cycles. Each pulse carries the byte read and its address in `out_addr`.
- R8: With `cfg_wrap` = 1, the address steps by one inside its aligned 16-byte block, so the low four bits roll over without carrying. With `cfg_wrap` = 0, it steps linearly and rolls from `0xFFFFFF` to `0x000000`.
- R9: After an `xip_enter` pulse, the next transaction still sends the opcode, and every later one sends only the address (24/lanes clocks before the dummy phase). After an `xip_exit` pulse, the next transaction sends the opcode again.
- R10: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high, and lane mode, dummy count and wrap are sampled at that moment. Changing them during the transaction has no effect on it.
- R11: A request with `req_len` = 0 reads exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lanes | input | 2 | Lane mode: 0 single, 1 dual, 2 quad, 3 single |
| cfg_dummy | input | 4 | Dummy clock count |
| cfg_wrap | input | 1 | Wrap inside 16-byte blocks when 1 |
| xip_enter | input | 1 | Pulse: arm execute-in-place |
| xip_exit | input | 1 | Pulse: leave execute-in-place |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | 24 | Start byte address |
| req_len | input | 16 | Byte count (0 reads one byte) |
| out_valid | output | 1 | One-cycle pulse per returned byte |
| out_data | output | 8 | Returned byte |
| out_addr | output | 24 | Address of the returned byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_dq_o | output | 4 | Data line drive values |
| spi_dq_oe | output | 4 | Data line drive enables |
| spi_dq_i | input | 4 | Data line input values |

## Verification
Chip select falls on the clock edge that accepts a request. Each serial clock then takes two system cycles: a low cycle that holds the launched bits and a high cycle that begins on the capture edge. A byte's `out_valid` pulse rises on the capture edge of its last clock and lasts through that high cycle. Chip select rises on the falling edge that ends the final data clock. The bench drives inputs and samples outputs on falling system-clock edges. It collects each byte during its pulse and waits for chip select to return high before comparing clock counts, bus header, bytes and addresses. At that point every result of the transaction is already settled.

// File: rtl/frd_pkg.sv
package frd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DUMMY,
        ST_DATA,
        ST_END
    } frd_state_e;

    typedef enum logic [1:0] {
        XIP_OFF,
        XIP_ARMED,
        XIP_ON
    } frd_xip_e;

    // log2 of the lane count; the unused code falls back to one lane
    function automatic logic [1:0] lane_log(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] lw);
        case (lw)
            2'd1:    return 4'b0011;
            2'd2:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [3:0] byte_clks(input logic [1:0] lw);
        return 4'(4'd8 >> lw);
    endfunction

    function automatic int unsigned lane_bits(input logic [1:0] lw);
        return 32'd1 << lw;
    endfunction

endpackage

// File: rtl/frd_lane_mux.sv
module frd_lane_mux (
    input  logic [1:0] lw,
    input  logic [3:0] tx_top,
    input  logic [7:0] rx_cur,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic [7:0] rx_nxt
);
    always_comb begin
        case (lw)
            2'd1: begin
                dq_o   = {2'b00, tx_top[3:2]};
                rx_nxt = {rx_cur[5:0], dq_i[1:0]};
            end
            2'd2: begin
                dq_o   = tx_top;
                rx_nxt = {rx_cur[3:0], dq_i};
            end
            default: begin
                dq_o   = {3'b000, tx_top[3]};
                rx_nxt = {rx_cur[6:0], dq_i[1]};
            end
        endcase
    end
endmodule

// File: rtl/frd_addr_step.sv
module frd_addr_step #(
    parameter int ADDR_W     = 24,
    parameter int WRAP_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wrap,
    output logic [ADDR_W-1:0] addr_nxt
);
    localparam int WL = $clog2(WRAP_BYTES);

    logic [ADDR_W-1:0] lin;
    logic [WL-1:0]     low;

    assign lin = addr + ADDR_W'(1);
    assign low = addr[WL-1:0] + WL'(1);

    always_comb begin
        addr_nxt = wrap ? {addr[ADDR_W-1:WL], low} : lin;
    end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl #(
    parameter int         ADDR_W     = 24,
    parameter int         LEN_W      = 16,
    parameter int         DUM_W      = 4,
    parameter int         WRAP_BYTES = 16,
    parameter logic [7:0] OPCODE     = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_lanes,
    input  logic [DUM_W-1:0]  cfg_dummy,
    input  logic              cfg_wrap,
    input  logic              xip_enter,
    input  logic              xip_exit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic [3:0]        spi_dq_o,
    output logic [3:0]        spi_dq_oe,
    input  logic [3:0]        spi_dq_i
);
    import frd_pkg::*;

    localparam int HDR_W   = ADDR_W + 8;
    localparam int DUM_MAX = (1 << DUM_W) - 1;
    localparam int CNT_W   = $clog2(((HDR_W > DUM_MAX) ? HDR_W : DUM_MAX) + 1);

    typedef struct packed {
        frd_state_e        st;
        frd_xip_e          xip;
        logic              ph;     // serial clock level
        logic              cs_n;
        logic [3:0]        oe;
        logic [1:0]        lw;
        logic [DUM_W-1:0]  dum;
        logic              wrap;
        logic [HDR_W-1:0]  sr;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        bcnt;
        logic [LEN_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        rx;
        logic              ov;
        logic [7:0]        od;
        logic [ADDR_W-1:0] oa;
    } frd_regs_t;

    frd_regs_t         r_q, r_d;
    logic              accept;
    logic [1:0]        lw_in;
    logic [7:0]        rx_nxt;
    logic [ADDR_W-1:0] addr_nxt;

    frd_lane_mux u_lane (
        .lw     (r_q.lw),
        .tx_top (r_q.sr[HDR_W-1:HDR_W-4]),
        .rx_cur (r_q.rx),
        .dq_i   (spi_dq_i),
        .dq_o   (spi_dq_o),
        .rx_nxt (rx_nxt)
    );

    frd_addr_step #(
        .ADDR_W     (ADDR_W),
        .WRAP_BYTES (WRAP_BYTES)
    ) u_step (
        .addr     (r_q.addr),
        .wrap     (r_q.wrap),
        .addr_nxt (addr_nxt)
    );

    assign lw_in  = lane_log(cfg_lanes);
    assign accept = req_valid && (r_q.st == ST_IDLE);

    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;

        // execute-in-place: the armed transaction still carries the opcode
        if (accept && r_q.xip == XIP_ARMED) r_d.xip = XIP_ON;
        if (xip_exit) r_d.xip = XIP_OFF;
        else if (xip_enter && r_d.xip == XIP_OFF) r_d.xip = XIP_ARMED;

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st   = ST_SEND;
                    r_d.cs_n = 1'b0;
                    r_d.ph   = 1'b0;
                    r_d.lw   = lw_in;
                    r_d.dum  = cfg_dummy;
                    r_d.wrap = cfg_wrap;
                    r_d.addr = req_addr;
                    r_d.left = (req_len == '0) ? LEN_W'(1) : req_len;
                    r_d.oe   = lane_mask(lw_in);
                    if (r_q.xip == XIP_ON) begin
                        r_d.sr  = {req_addr, 8'h00};
                        r_d.cnt = CNT_W'(ADDR_W >> lw_in);
                    end else begin
                        r_d.sr  = {OPCODE, req_addr};
                        r_d.cnt = CNT_W'(HDR_W >> lw_in);
                    end
                end
            end
            ST_SEND: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.ph  = 1'b0;
                    r_d.sr  = r_q.sr << lane_bits(r_q.lw);
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.oe = 4'b0000;
                        if (r_q.dum != '0) begin
                            r_d.st  = ST_DUMMY;
                            r_d.cnt = CNT_W'(r_q.dum);
                        end else begin
                            r_d.st   = ST_DATA;
                            r_d.bcnt = byte_clks(r_q.lw);
                        end
                    end
                end
            end
            ST_DUMMY: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else begin
                    r_d.ph  = 1'b0;
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st   = ST_DATA;
                        r_d.bcnt = byte_clks(r_q.lw);
                    end
                end
            end
            ST_DATA: begin
                if (!r_q.ph) begin
                    // rising edge: capture the lanes
                    r_d.ph = 1'b1;
                    r_d.rx = rx_nxt;
                    if (r_q.bcnt == 4'd1) begin
                        r_d.ov   = 1'b1;
                        r_d.od   = rx_nxt;
                        r_d.oa   = r_q.addr;
                        r_d.addr = addr_nxt;
                        r_d.left = r_q.left - LEN_W'(1);
                        r_d.bcnt = byte_clks(r_q.lw);
                    end else begin
                        r_d.bcnt = r_q.bcnt - 4'd1;
                    end
                end else begin
                    r_d.ph = 1'b0;
                    if (r_q.left == '0) begin
                        r_d.st   = ST_END;
                        r_d.cs_n = 1'b1;
                    end
                end
            end
            ST_END:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.xip  <= XIP_OFF;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign spi_cs_n  = r_q.cs_n;
    assign spi_sck   = r_q.ph;
    assign spi_dq_oe = r_q.oe;
    assign out_valid = r_q.ov;
    assign out_data  = r_q.od;
    assign out_addr  = r_q.oa;

endmodule

// File: rtl/frd_rd_checker.sv
module frd_rd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic [3:0] spi_dq_o,
    input logic [3:0] spi_dq_oe,
    input logic       req_ready,
    input logic       out_valid
);
    // R1: clock parked low and lines released outside a transaction
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && spi_dq_oe == 4'b0000));

    // R6: launched values move only with a falling serial clock
    p_launch_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$past(spi_cs_n) && !$fell(spi_sck))
        |-> ($stable(spi_dq_o) && $stable(spi_dq_oe)));

    // R5: the controller never drives while a byte is delivered
    p_released_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (spi_dq_oe == 4'b0000));

    // R3: the enable pattern is one of the lane masks
    p_oe_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_dq_oe == 4'b0000 || spi_dq_oe == 4'b0001 ||
         spi_dq_oe == 4'b0011 || spi_dq_oe == 4'b1111));

    // R7: byte pulses are isolated
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10: ready only with the bus idle
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);
endmodule

bind flash_rd_ctrl frd_rd_checker u_frd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_dq_o  (spi_dq_o),
    .spi_dq_oe (spi_dq_oe),
    .req_ready (req_ready),
    .out_valid (out_valid)
);

// File: tb/flash_rd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_rd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_lanes = 2'd0;
    logic [3:0]  cfg_dummy = 4'd0;
    logic        cfg_wrap = 1'b0;
    logic        xip_enter = 1'b0;
    logic        xip_exit = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [23:0] out_addr;
    logic        spi_cs_n, spi_sck;
    logic [3:0]  spi_dq_o, spi_dq_oe;
    logic [3:0]  mdq = 4'd0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // memory model state
    int          nclk = 0;
    logic [31:0] hdr = '0;
    int          m_L = 1;
    int          m_dummy = 0;
    bit          m_skip = 1'b0;
    bit          m_wrap = 1'b0;
    int          oe_bad = 0;
    int          edge_bad = 0;
    int          cs_falls = 0;
    logic [3:0]  pdo = '0;
    logic [3:0]  poe = '0;
    logic [7:0]  got_d[$];
    logic [23:0] got_a[$];

    always #2 clk = ~clk;

    flash_rd_ctrl u_flash_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lanes (cfg_lanes),
        .cfg_dummy (cfg_dummy),
        .cfg_wrap  (cfg_wrap),
        .xip_enter (xip_enter),
        .xip_exit  (xip_exit),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_addr  (out_addr),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_dq_o  (spi_dq_o),
        .spi_dq_oe (spi_dq_oe),
        .spi_dq_i  (mdq)
    );

    function automatic logic [7:0] ref_byte(input logic [23:0] a);
        return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
    endfunction

    function automatic logic [23:0] next_a(input logic [23:0] a, input bit w);
        return w ? {a[23:4], 4'(a[3:0] + 4'd1)} : 24'(a + 24'd1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---- behavioural flash model ----
    always @(negedge spi_cs_n) begin
        nclk = 0;
        hdr = '0;
        mdq = 4'd0;
        cs_falls++;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            int hc;
            hc = (m_skip ? 24 : 32) / m_L;
            if (nclk < hc) begin
                hdr = (hdr << m_L) | 32'(spi_dq_o & 4'((1 << m_L) - 1));
                if (spi_dq_oe != 4'((1 << m_L) - 1)) oe_bad++;
            end else if (spi_dq_oe != 4'd0) begin
                oe_bad++;
            end
            nclk++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            int hd, j, cpb, b, s;
            logic [23:0] a;
            logic [7:0]  v;
            hd = (m_skip ? 24 : 32) / m_L + m_dummy;
            if (nclk >= hd) begin
                j = nclk - hd;
                cpb = 8 / m_L;
                b = j / cpb;
                s = j % cpb;
                a = hdr[23:0];
                for (int k = 0; k < b; k++) a = next_a(a, m_wrap);
                v = ref_byte(a) << (s * m_L);
                case (m_L)
                    1:       mdq = {2'b00, v[7], 1'b0};
                    2:       mdq = {2'b00, v[7:6]};
                    default: mdq = v[7:4];
                endcase
            end
        end
    end

    // ---- port monitor ----
    always @(negedge clk) begin
        if (!spi_cs_n && spi_sck && (spi_dq_o !== pdo || spi_dq_oe !== poe)) edge_bad++;
        pdo = spi_dq_o;
        poe = spi_dq_oe;
        if (out_valid) begin
            got_d.push_back(out_data);
            got_a.push_back(out_addr);
        end
    end

    task automatic do_read(input logic [23:0] a, input int len, input int lc,
                           input int dm, input bit wr, input bit skip,
                           input string tag, input bit perturb);
        int L, n, exp_clk;
        logic [23:0] ea;
        bit okd, oka;
        L = 1 << lc;
        n = (len == 0) ? 1 : len;
        cfg_lanes = 2'(lc);
        cfg_dummy = 4'(dm);
        cfg_wrap = wr;
        m_L = L;
        m_dummy = dm;
        m_skip = skip;
        m_wrap = wr;
        got_d.delete();
        got_a.delete();
        edge_bad = 0;
        oe_bad = 0;
        cs_falls = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_len = 16'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (perturb) begin
            cfg_lanes = 2'((lc + 1) % 3);
            cfg_dummy = 4'(dm + 3);
            cfg_wrap = !wr;
            @(negedge clk);
            check(!req_ready, "R10", "ready while busy", req_ready, 0);
        end
        while (!spi_cs_n) @(negedge clk);
        @(negedge clk);
        exp_clk = (skip ? 24 : 32) / L + dm + 8 * n / L;
        check(nclk == exp_clk, tag, "serial clocks", nclk, exp_clk);
        if (!skip) check(hdr[31:24] == 8'h0B, tag, "opcode on bus", hdr[31:24], 8'h0B);
        check(hdr[23:0] == a, tag, "address on bus", hdr[23:0], a);
        check(got_d.size() == n, "R7", "byte count", got_d.size(), n);
        okd = 1'b1;
        oka = 1'b1;
        ea = a;
        for (int i = 0; i < got_d.size(); i++) begin
            if (got_d[i] !== ref_byte(ea)) okd = 1'b0;
            if (got_a[i] !== ea) oka = 1'b0;
            ea = next_a(ea, wr);
        end
        check(okd, tag, "returned bytes", okd, 1);
        check(oka, "R8", "byte addresses", oka, 1);
        check(edge_bad == 0, "R6", "launch on falling edge only", edge_bad, 0);
        check(cs_falls == 1, "R6", "chip select falls once", cs_falls, 1);
        check(oe_bad == 0, "R5", "enable pattern per phase", oe_bad, 0);
    endtask

    task automatic pulse_xip(input bit enter);
        @(negedge clk);
        if (enter) xip_enter = 1'b1; else xip_exit = 1'b1;
        @(negedge clk);
        xip_enter = 1'b0;
        xip_exit = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
        check(spi_dq_oe == 4'd0, "R1", "oe after reset", spi_dq_oe, 0);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    endtask

    task automatic t_single();
        do_read(24'h001230, 5, 0, 8, 1'b0, 1'b0, "R2", 1'b0);
        do_read(24'hABCDEF, 3, 0, 0, 1'b0, 1'b0, "R5", 1'b0);
    endtask

    task automatic t_dual();
        do_read(24'h345671, 6, 1, 4, 1'b0, 1'b0, "R3", 1'b0);
    endtask

    task automatic t_quad();
        do_read(24'h7FFF00, 9, 2, 6, 1'b0, 1'b0, "R4", 1'b0);
        do_read(24'h00F0F0, 2, 2, 0, 1'b0, 1'b0, "R5", 1'b0);
    endtask

    task automatic t_wrap();
        do_read(24'h12345C, 10, 2, 2, 1'b1, 1'b0, "R8", 1'b0);
        do_read(24'hFFFFFE, 4, 1, 1, 1'b0, 1'b0, "R8", 1'b0);
    endtask

    task automatic t_len_zero();
        do_read(24'h000777, 0, 0, 3, 1'b0, 1'b0, "R11", 1'b0);
    endtask

    task automatic t_cfg_hold();
        do_read(24'h0A0B0C, 4, 1, 2, 1'b0, 1'b0, "R10", 1'b1);
    endtask

    task automatic t_xip();
        pulse_xip(1'b1);
        do_read(24'h400010, 3, 2, 4, 1'b0, 1'b0, "R9", 1'b0);
        do_read(24'h400020, 4, 2, 4, 1'b0, 1'b1, "R9", 1'b0);
        do_read(24'h2A0003, 2, 0, 2, 1'b1, 1'b1, "R9", 1'b0);
        pulse_xip(1'b0);
        do_read(24'h5A5A5A, 3, 1, 3, 1'b0, 1'b0, "R9", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_dual();
        t_quad();
        t_wrap();
        t_len_zero();
        t_cfg_hold();
        t_xip();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule